// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit handles the modem-line side of a 16550-style serial port. A host writes a control byte that drives four active-low modem outputs: data-terminal-ready, request-to-send and two auxiliary lines. It can read that byte back. The host also reads a status byte. Its upper nibble shows the present asserted-true level of the four modem inputs. Its lower nibble holds sticky change flags that clear when the host reads the byte.

Each time a modem input level changes, the unit emits a one-cycle notification strobe carrying the status byte. A host can use this as an unsolicited event instead of polling. A loopback mode routes the modem outputs back onto the inputs internally so the path can be diagnosed. While it is on, the external outputs are parked inactive.

External inputs are synchronised through a chain of flops before any edge is detected. The host read and write strobes are single-cycle and synchronous to the unit's clock.

Top module: `modem_ctrl_unit`

## Requirements
- R1: Status bits 7, 6, 5 and 4 show the asserted-true level of carrier-detect, ring, data-set-ready and clear-to-send. An input pin driven low reads as 1.
- R2: Status bits 3, 1 and 0 become 1 on any level change of carrier-detect, data-set-ready and clear-to-send respectively. They stay 1 until a host read, even if the line returns to its earlier level.
- R3: Status bit 2 becomes 1 only when the ring pin goes from low to high, which is the end of a ring. The start of a ring leaves it 0.
- R4: A host read (`sts_rd` high at a clock edge) clears status bits 3..0 at that edge. A change that is detected at the same edge remains set afterwards.
- R5: Control bit 0 drives DTR, bit 1 RTS, bit 2 OUT1 and bit 3 OUT2. A 1 drives the matching active-low pin low. Control 0x08 leaves DTR and RTS high, 0x0A drives only RTS low, and 0x09 drives only DTR low. OUT2 is low in all three.
- R6: `ctl_rdata` returns control bits 4..0 as last written, and bits 7..5 always read 0.
- R7: With control bit 4 set, the input levels come from the control bits: RTS to clear-to-send, DTR to data-set-ready, OUT1 to ring, and OUT2 to carrier-detect. The four output pins are held high, and the external input pins have no effect.
- R8: After any modem input level change, `ntf_valid` is high for exactly one cycle. During that cycle `ntf_data` equals `sts_rdata`.
- R9: An external input pin change appears in the status byte and in the notification after SYNC_STAGES+1 clock edges (three with the default).
- R10: After reset, the control byte is 0, all output pins are high, the status byte is 0 with the input pins high, and `ntf_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte to write |
| ctl_rdata | output | 8 | Control byte readback |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_rdata | output | 8 | Status byte (levels and change flags) |
| ntf_valid | output | 1 | One-cycle notification of an input change |
| ntf_data | output | 8 | Status byte carried by the notification |
| pin_dtr_n | output | 1 | Data-terminal-ready, active low |
| pin_rts_n | output | 1 | Request-to-send, active low |
| pin_out1_n | output | 1 | Auxiliary output 1, active low |
| pin_out2_n | output | 1 | Auxiliary output 2, active low |
| pin_cd_n | input | 1 | Carrier-detect, active low, asynchronous |
| pin_ri_n | input | 1 | Ring, active low, asynchronous |
| pin_dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| pin_cts_n | input | 1 | Clear-to-send, active low, asynchronous |

## Verification
The assertions assume that the modem input pins are high throughout reset, so the synchroniser reset value of all-ones creates no false change. They also assume that `sts_rd` and `ctl_wr` are single-cycle pulses aligned to the clock. The stimulus changes pins and strobes only at the falling clock edge and keeps the pins inactive during reset. Each scenario starts from a clean state: all pins high, loopback off, and a status read to clear the flags.

// File: rtl/mcsu_pkg.sv
package mcsu_pkg;
   localparam int BYTE_W  = 8;
   localparam int N_LINES = 4;
   localparam int CTL_W   = 5;

   // index of each modem input inside a line vector; also its status bit
   // position (level at idx+4, change flag at idx)
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_CD  = 3;

   // control bit positions
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;

   typedef logic [N_LINES-1:0] lines_t;
   typedef logic [CTL_W-1:0]   ctl_t;
endpackage

// File: rtl/mcsu_sync.sv
module mcsu_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mcsu_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mcsu_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '1;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mcsu_delta.sv
module mcsu_delta
   import mcsu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  lines_t cur,
   input  logic   clr,
   output lines_t lvl_q,
   output lines_t delta_q,
   output lines_t delta_nxt,
   output logic   chg
);
   lines_t evt;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      if (i == LN_RI) begin : g_trail
         // ring flag: asserted-true level falling means the pin went high
         assign evt[i] = lvl_q[i] & ~cur[i];
      end else begin : g_any
         assign evt[i] = lvl_q[i] ^ cur[i];
      end
   end

   assign chg       = |(lvl_q ^ cur);
   assign delta_nxt = (delta_q & ~{N_LINES{clr}}) | evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         delta_q <= '0;
      end else begin
         lvl_q   <= cur;
         delta_q <= delta_nxt;
      end
   end

   // R2: a flag holds while no read is made
   p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && delta_q[LN_CTS]) |=> delta_q[LN_CTS]);

   // R3: ring flag rises only together with a falling ring level
   p_ring_trail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(delta_q[LN_RI]) |-> ($past(lvl_q[LN_RI]) && !lvl_q[LN_RI]));

   // R4: after a read, any remaining flag stems from a level change at that edge
   p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((delta_q == '0) || (lvl_q != $past(lvl_q))));
endmodule

// File: rtl/modem_ctrl_unit.sv
module modem_ctrl_unit
   import mcsu_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [BYTE_W-1:0] ctl_wdata,
   output logic [BYTE_W-1:0] ctl_rdata,
   input  logic              sts_rd,
   output logic [BYTE_W-1:0] sts_rdata,
   output logic              ntf_valid,
   output logic [BYTE_W-1:0] ntf_data,
   output logic              pin_dtr_n,
   output logic              pin_rts_n,
   output logic              pin_out1_n,
   output logic              pin_out2_n,
   input  logic              pin_cd_n,
   input  logic              pin_ri_n,
   input  logic              pin_dsr_n,
   input  logic              pin_cts_n
);
   localparam int PAD_W = BYTE_W - CTL_W;

   if (BYTE_W != 2 * N_LINES) begin : g_bad_byte
      $error("modem_ctrl_unit: status byte must hold levels and flags");
   end

   ctl_t   ctl_q;
   lines_t ext_n_raw, ext_n_sync, loop_lvl, cur;
   lines_t lvl_q, delta_q, delta_nxt;
   logic   chg;
   logic   loop_on;

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_wdata[CTL_W-1:0];
   end
   assign ctl_rdata = {{PAD_W{1'b0}}, ctl_q};
   assign loop_on   = ctl_q[CB_LOOP];

   // output pins, parked high in loopback
   assign pin_dtr_n  = loop_on | ~ctl_q[CB_DTR];
   assign pin_rts_n  = loop_on | ~ctl_q[CB_RTS];
   assign pin_out1_n = loop_on | ~ctl_q[CB_OUT1];
   assign pin_out2_n = loop_on | ~ctl_q[CB_OUT2];

   // input capture
   always_comb begin
      ext_n_raw         = '1;
      ext_n_raw[LN_CTS] = pin_cts_n;
      ext_n_raw[LN_DSR] = pin_dsr_n;
      ext_n_raw[LN_RI]  = pin_ri_n;
      ext_n_raw[LN_CD]  = pin_cd_n;
   end

   mcsu_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_n_raw),
      .q     (ext_n_sync)
   );

   always_comb begin
      loop_lvl         = '0;
      loop_lvl[LN_CTS] = ctl_q[CB_RTS];
      loop_lvl[LN_DSR] = ctl_q[CB_DTR];
      loop_lvl[LN_RI]  = ctl_q[CB_OUT1];
      loop_lvl[LN_CD]  = ctl_q[CB_OUT2];
   end

   assign cur = loop_on ? loop_lvl : ~ext_n_sync;

   mcsu_delta u_delta (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur       (cur),
      .clr       (sts_rd),
      .lvl_q     (lvl_q),
      .delta_q   (delta_q),
      .delta_nxt (delta_nxt),
      .chg       (chg)
   );

   assign sts_rdata = {lvl_q, delta_q};

   // notification
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ntf_valid <= 1'b0;
         ntf_data  <= '0;
      end else begin
         ntf_valid <= chg;
         ntf_data  <= {cur, delta_nxt};
      end
   end

   // R8: the notified byte is the status byte of that cycle
   p_ntf_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> (ntf_data == sts_rdata));

   // R8: a notification follows a level change
   p_ntf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> (lvl_q != $past(lvl_q)));

   // R7: in steady loopback the clear-to-send level tracks RTS
   p_loop_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CB_LOOP] && $past(ctl_q[CB_LOOP]))
         |-> (sts_rdata[BYTE_W/2 + LN_CTS] == $past(ctl_q[CB_RTS])));

   // R7: loopback leaves all outputs inactive
   p_loop_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[CB_LOOP]) |-> (pin_dtr_n && pin_rts_n && pin_out1_n && pin_out2_n));
endmodule

// File: tb/modem_ctrl_unit_tb.sv
module modem_ctrl_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       sts_rd = 1'b0;
   logic [7:0] sts_rdata;
   logic       ntf_valid;
   logic [7:0] ntf_data;
   logic       pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n;
   logic       pin_cd_n = 1'b1, pin_ri_n = 1'b1, pin_dsr_n = 1'b1, pin_cts_n = 1'b1;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   modem_ctrl_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .sts_rd(sts_rd), .sts_rdata(sts_rdata),
      .ntf_valid(ntf_valid), .ntf_data(ntf_data),
      .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
      .pin_out1_n(pin_out1_n), .pin_out2_n(pin_out2_n),
      .pin_cd_n(pin_cd_n), .pin_ri_n(pin_ri_n),
      .pin_dsr_n(pin_dsr_n), .pin_cts_n(pin_cts_n)
   );

   function automatic logic [7:0] pins4();
      return {4'h0, pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n};
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wdata = v;
      ctl_wr = 1'b1;
      tick(1);
      ctl_wr = 1'b0;
   endtask

   task automatic rd_sts();
      sts_rd = 1'b1;
      tick(1);
      sts_rd = 1'b0;
   endtask

   task automatic clean();
      wr_ctl(8'h00);
      pin_cd_n = 1'b1; pin_ri_n = 1'b1; pin_dsr_n = 1'b1; pin_cts_n = 1'b1;
      tick(5);
      rd_sts();
      tick(1);
   endtask

   task automatic t_reset();
      chk(ctl_rdata, 8'h00, "R10 control after reset");
      chk(pins4(), 8'h0F, "R10 pins after reset");
      chk(sts_rdata, 8'h00, "R10 status after reset");
      chk({7'h0, ntf_valid}, 8'h00, "R10 no notification after reset");
   endtask

   task automatic t_control();
      wr_ctl(8'h08);
      chk(pins4(), 8'h07, "R5 0x08 only OUT2 active");
      wr_ctl(8'h0A);
      chk(pins4(), 8'h05, "R5 0x0A RTS and OUT2 active");
      wr_ctl(8'h09);
      chk(pins4(), 8'h06, "R5 0x09 DTR and OUT2 active");
      wr_ctl(8'hE7);
      chk(ctl_rdata, 8'h07, "R6 reserved bits read zero");
      chk(pins4(), 8'h08, "R5 DTR RTS OUT1 active");
      clean();
   endtask

   task automatic t_latency();
      pin_cts_n = 1'b0;
      tick(2);
      chk(sts_rdata, 8'h00, "R9 not yet visible after two edges");
      tick(1);
      chk(sts_rdata, 8'h11, "R1 R9 cts level and flag");
      chk({7'h0, ntf_valid}, 8'h01, "R8 notification strobe");
      chk(ntf_data, 8'h11, "R8 notification byte");
      tick(1);
      chk({7'h0, ntf_valid}, 8'h00, "R8 strobe lasts one cycle");
      rd_sts();
      chk(sts_rdata, 8'h10, "R4 read clears flag, level stays");
      clean();
   endtask

   task automatic t_sticky();
      pin_dsr_n = 1'b0;
      tick(4);
      pin_dsr_n = 1'b1;
      tick(4);
      chk(sts_rdata, 8'h02, "R2 dsr flag sticky after return");
      pin_cd_n = 1'b0;
      tick(4);
      chk(sts_rdata, 8'h8A, "R1 R2 cd level and flag");
      rd_sts();
      chk(sts_rdata, 8'h80, "R4 flags cleared by read");
      clean();
   endtask

   task automatic t_ring();
      pin_ri_n = 1'b0;
      tick(3);
      chk(ntf_data, 8'h40, "R3 R8 ring start notified without flag");
      tick(1);
      chk(sts_rdata, 8'h40, "R3 ring start sets no flag");
      pin_ri_n = 1'b1;
      tick(4);
      chk(sts_rdata, 8'h04, "R3 ring end sets flag");
      clean();
   endtask

   task automatic t_read_race();
      pin_dsr_n = 1'b0;
      tick(4);
      chk(sts_rdata, 8'h22, "R2 dsr flag before race");
      pin_cts_n = 1'b0;
      tick(2);
      sts_rd = 1'b1;
      tick(1);
      sts_rd = 1'b0;
      chk(sts_rdata, 8'h31, "R4 change at read edge kept, old flag cleared");
      clean();
   endtask

   task automatic t_loop();
      pin_cts_n = 1'b0;
      tick(4);
      rd_sts();
      chk(sts_rdata, 8'h10, "R7 external cts before loopback");
      wr_ctl(8'h1B);
      chk(pins4(), 8'h0F, "R7 pins parked in loopback");
      tick(1);
      chk(sts_rdata, 8'hBA, "R7 loop levels from control");
      pin_cts_n = 1'b1;
      pin_ri_n = 1'b0;
      tick(4);
      chk(sts_rdata, 8'hBA, "R7 external inputs ignored");
      rd_sts();
      wr_ctl(8'h14);
      tick(1);
      chk(sts_rdata, 8'h4B, "R7 OUT1 feeds ring");
      rd_sts();
      wr_ctl(8'h10);
      tick(1);
      chk(sts_rdata, 8'h04, "R3 R7 loop ring end flagged");
      wr_ctl(8'h03);
      chk(pins4(), 8'h0C, "R5 pins return after loopback");
      clean();
   endtask

   initial begin
      #500000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_control();
      t_latency();
      t_sticky();
      t_ring();
      t_read_race();
      t_loop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule